// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block is the digital half of a supply supervisor. Analog comparators report whether the supply has crossed the power-on point, whether it has fallen under the brown-out level, and whether it has fallen under the early-warning level. The block turns those reports into a system reset, a sticky early-warning interrupt, enable lines for the two analog detectors, and clamped level selects for them.

Brown-out monitoring is switched on by a static option input that software cannot change. The early warning is switched on by a software enable. When software asks for it, both detectors are turned off when the chip enters deep sleep and turned back on when a wakeup event arrives. After a wakeup their outputs are ignored for a programmable number of cycles, which lets the analog parts settle. A build-time variant without brown-out monitoring releases reset only after a fixed count of cycles has passed with the supply above the power-on point.

A brown-out drives reset low in the same cycle it is seen, with no clock edge in the path. Reset is released on a clock edge after a minimum hold time.

Top module: `supply_supervisor`

## Requirements
- R1: `sys_rst_n_o` is 0 whenever `por_ok_i` is 0, whatever the other inputs and however long the supply stays low.
- R2: With brown-out monitoring built in (`NO_BOR`=0), `sys_rst_n_o` stays 0 for the first HOLD_CYC rising edges that see `por_ok_i`=1 with no brown-out trip. It becomes 1 after the next edge.
- R3: When the option `bor_opt_en_i`=1 and the detector is armed, `bor_low_i`=1 drives `sys_rst_n_o` to 0 in the same cycle, before any clock edge. After `bor_low_i` returns to 0, release follows the same HOLD_CYC+1 edge count as R2.
- R4: When `bor_opt_en_i`=0, `bor_en_o` is 0 and `bor_low_i` has no effect on `sys_rst_n_o`.
- R5: `bor_sel_o` equals `bor_lvl_i` clamped to the range 0..4 (five levels). Any value of 5 or more gives 4.
- R6: `pvd_en_o` = `pvd_sw_en_i` while not gated. When the detector is armed, `pvd_low_i`=1 sets `pvd_irq_o` at the next edge. The flag stays at 1 until an edge that sees `pvd_clr_i`=1 with no new set. A set at the same edge as a clear wins.
- R7: `pvd_sel_o` equals `pvd_lvl_i` clamped to the range 0..6 (seven levels). A value of 7 gives 6.
- R8: An edge that sees `deep_sleep_i`=1 and `sleep_gate_en_i`=1 drives `bor_en_o` and `pvd_en_o` to 0 after that edge. They stay at 0, with both comparator inputs ignored, until an edge that sees `wake_i`=1. With `sleep_gate_en_i`=0, deep sleep gates nothing.
- R9: The edge that ends gating loads `settle_cnt_i`. Both comparator inputs are ignored until that many further edges have passed, and they act again from the cycle that follows.
- R10: With `NO_BOR`=1, `bor_en_o` is always 0, `bor_low_i` is ignored, and reset is released after the edge that follows POR_DLY edges with `por_ok_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| pwr_rst_n | input | 1 | Active-low reset of the supervisor's own registers |
| por_ok_i | input | 1 | 1 when the supply is above the power-on point |
| bor_opt_en_i | input | 1 | Static option: brown-out monitoring on |
| bor_lvl_i | input | 3 | Requested brown-out level |
| bor_low_i | input | 1 | 1 when the supply is below the brown-out level |
| pvd_sw_en_i | input | 1 | Software enable of the early-warning detector |
| pvd_lvl_i | input | 3 | Requested early-warning level |
| pvd_low_i | input | 1 | 1 when the supply is below the early-warning level |
| pvd_clr_i | input | 1 | Write-one-to-clear of the early-warning flag |
| sleep_gate_en_i | input | 1 | Turn the detectors off during deep sleep |
| deep_sleep_i | input | 1 | Chip is in deep sleep |
| wake_i | input | 1 | Wakeup event |
| settle_cnt_i | input | SETTLE_W | Cycles the detector outputs are ignored after wake |
| sys_rst_n_o | output | 1 | Active-low system reset |
| pvd_irq_o | output | 1 | Sticky early-warning interrupt |
| bor_en_o | output | 1 | Enable of the brown-out comparator |
| bor_sel_o | output | 3 | Clamped brown-out level select |
| pvd_en_o | output | 1 | Enable of the early-warning comparator |
| pvd_sel_o | output | 3 | Clamped early-warning level select |

## Verification
A hold counter in a wrong state shows up as reset being released one or more edges early or late, so the bench counts edges exactly after each power-up and each brown-out. A gate or settle register in a wrong state shows up at once: either the enable lines are wrong in the cycle after the sleep or wake edge, or a comparator pulse inside the settle window pulls reset low or sets the flag. A flag error is visible one edge after the set or clear that exposes it.

// File: rtl/supsup_pkg.sv
package supsup_pkg;

    localparam int unsigned LVL_W = 3;

    typedef logic [LVL_W-1:0] lvl_t;

    // Limit a requested level to the highest one the detector offers
    function automatic lvl_t clamp_lvl(lvl_t v, int unsigned n_levels);
        lvl_t top;
        top = lvl_t'(n_levels - 1);
        return (v > top) ? top : v;
    endfunction

endpackage

// File: rtl/supsup_gate.sv
module supsup_gate #(
    parameter int unsigned SETTLE_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                gate_en_i,
    input  logic                deep_sleep_i,
    input  logic                wake_i,
    input  logic [SETTLE_W-1:0] settle_cnt_i,
    output logic                gated_o,
    output logic                settled_o
);

    typedef struct packed {
        logic                gated;
        logic [SETTLE_W-1:0] settle;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.gated && wake_i) begin
            st_d.gated  = 1'b0;
            st_d.settle = settle_cnt_i;
        end else begin
            st_d.gated = st_q.gated | (deep_sleep_i & gate_en_i);
            if (st_q.settle != '0) begin
                st_d.settle = st_q.settle - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gated_o   = st_q.gated;
    assign settled_o = (st_q.settle == '0);

    // R8
    gate_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.gated && !wake_i) |=> st_q.gated);

    // R9
    settle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.gated && wake_i) |=> (!st_q.gated && st_q.settle == $past(settle_cnt_i)));

endmodule

// File: rtl/supsup_rstseq.sv
module supsup_rstseq #(
    parameter int unsigned LOAD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_ok_i,
    input  logic trip_i,
    output logic sys_rst_n_o
);

    localparam int unsigned CNT_W = $clog2(LOAD + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rel;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!por_ok_i || trip_i) begin
            st_d.cnt = CNT_W'(LOAD);
            st_d.rel = 1'b0;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            st_d.rel = 1'b0;
        end else begin
            st_d.rel = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= CNT_W'(LOAD);
            st_q.rel <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // Assert path has no register; release path is registered
    assign sys_rst_n_o = st_q.rel & por_ok_i & ~trip_i;

    // R2
    release_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rel |-> (st_q.cnt == '0));

    // R1
    por_low_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !por_ok_i |=> !st_q.rel);

    // R3
    trip_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip_i |=> !st_q.rel);

endmodule

// File: rtl/supsup_flag.sv
module supsup_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = (flag_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);

endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
    import supsup_pkg::*;
#(
    parameter bit          NO_BOR     = 1'b0,
    parameter int unsigned HOLD_CYC   = 6,
    parameter int unsigned POR_DLY    = 10,
    parameter int unsigned SETTLE_W   = 4,
    parameter int unsigned BOR_LEVELS = 5,
    parameter int unsigned PVD_LEVELS = 7
) (
    input  logic                clk,
    input  logic                pwr_rst_n,
    input  logic                por_ok_i,
    input  logic                bor_opt_en_i,
    input  logic [2:0]          bor_lvl_i,
    input  logic                bor_low_i,
    input  logic                pvd_sw_en_i,
    input  logic [2:0]          pvd_lvl_i,
    input  logic                pvd_low_i,
    input  logic                pvd_clr_i,
    input  logic                sleep_gate_en_i,
    input  logic                deep_sleep_i,
    input  logic                wake_i,
    input  logic [SETTLE_W-1:0] settle_cnt_i,
    output logic                sys_rst_n_o,
    output logic                pvd_irq_o,
    output logic                bor_en_o,
    output logic [2:0]          bor_sel_o,
    output logic                pvd_en_o,
    output logic [2:0]          pvd_sel_o
);

    localparam int unsigned LOAD = NO_BOR ? POR_DLY : HOLD_CYC;

    logic gated, settled, bor_trip, pvd_set;

    supsup_gate #(.SETTLE_W(SETTLE_W)) u_gate (
        .clk          (clk),
        .rst_n        (pwr_rst_n),
        .gate_en_i    (sleep_gate_en_i),
        .deep_sleep_i (deep_sleep_i),
        .wake_i       (wake_i),
        .settle_cnt_i (settle_cnt_i),
        .gated_o      (gated),
        .settled_o    (settled)
    );

    generate
        if (NO_BOR) begin : g_fixed_delay
            assign bor_en_o = 1'b0;
        end else begin : g_bor
            assign bor_en_o = bor_opt_en_i & ~gated;
        end
    endgenerate

    assign pvd_en_o  = pvd_sw_en_i & ~gated;
    assign bor_trip  = bor_en_o & settled & bor_low_i;
    assign pvd_set   = pvd_en_o & settled & pvd_low_i;
    assign bor_sel_o = clamp_lvl(bor_lvl_i, BOR_LEVELS);
    assign pvd_sel_o = clamp_lvl(pvd_lvl_i, PVD_LEVELS);

    supsup_rstseq #(.LOAD(LOAD)) u_seq (
        .clk         (clk),
        .rst_n       (pwr_rst_n),
        .por_ok_i    (por_ok_i),
        .trip_i      (bor_trip),
        .sys_rst_n_o (sys_rst_n_o)
    );

    supsup_flag u_flag (
        .clk    (clk),
        .rst_n  (pwr_rst_n),
        .set_i  (pvd_set),
        .clr_i  (pvd_clr_i),
        .flag_o (pvd_irq_o)
    );

    // R5
    bor_sel_range_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        bor_sel_o <= 3'(BOR_LEVELS - 1));

    // R7
    pvd_sel_range_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        pvd_sel_o <= 3'(PVD_LEVELS - 1));

    // R8
    gated_enables_off_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        (deep_sleep_i && sleep_gate_en_i && !wake_i) |=> (!bor_en_o && !pvd_en_o));

    // R10
    no_bor_variant_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        NO_BOR |-> !bor_en_o);

endmodule

// File: tb/supply_supervisor_tb.sv
module supply_supervisor_tb;

    localparam int unsigned HOLD = 6;
    localparam int unsigned PDLY = 10;
    localparam int unsigned SW   = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic pwr_rst_n, por_ok, bor_opt, bor_low, pvd_sw, pvd_low, pvd_clr;
    logic gate_en, dsleep, wake;
    logic [2:0] bor_lvl, pvd_lvl;
    logic [SW-1:0] settle;
    logic rst_n_a, irq_a, bor_en_a, pvd_en_a;
    logic [2:0] bsel_a, psel_a;
    logic rst_n_b, irq_b, bor_en_b, pvd_en_b;
    logic [2:0] bsel_b, psel_b;

    int n_chk = 0;
    int n_bad = 0;

    supply_supervisor #(.NO_BOR(1'b0), .HOLD_CYC(HOLD), .POR_DLY(PDLY), .SETTLE_W(SW)) u_dut (
        .clk(clk), .pwr_rst_n(pwr_rst_n), .por_ok_i(por_ok), .bor_opt_en_i(bor_opt),
        .bor_lvl_i(bor_lvl), .bor_low_i(bor_low), .pvd_sw_en_i(pvd_sw), .pvd_lvl_i(pvd_lvl),
        .pvd_low_i(pvd_low), .pvd_clr_i(pvd_clr), .sleep_gate_en_i(gate_en),
        .deep_sleep_i(dsleep), .wake_i(wake), .settle_cnt_i(settle),
        .sys_rst_n_o(rst_n_a), .pvd_irq_o(irq_a), .bor_en_o(bor_en_a), .bor_sel_o(bsel_a),
        .pvd_en_o(pvd_en_a), .pvd_sel_o(psel_a));

    supply_supervisor #(.NO_BOR(1'b1), .HOLD_CYC(HOLD), .POR_DLY(PDLY), .SETTLE_W(SW)) u_dut_nb (
        .clk(clk), .pwr_rst_n(pwr_rst_n), .por_ok_i(por_ok), .bor_opt_en_i(bor_opt),
        .bor_lvl_i(bor_lvl), .bor_low_i(bor_low), .pvd_sw_en_i(pvd_sw), .pvd_lvl_i(pvd_lvl),
        .pvd_low_i(pvd_low), .pvd_clr_i(pvd_clr), .sleep_gate_en_i(gate_en),
        .deep_sleep_i(dsleep), .wake_i(wake), .settle_cnt_i(settle),
        .sys_rst_n_o(rst_n_b), .pvd_irq_o(irq_b), .bor_en_o(bor_en_b), .bor_sel_o(bsel_b),
        .pvd_en_o(pvd_en_b), .pvd_sel_o(psel_b));

    // {bor_lvl, pvd_lvl, expected bor_sel, expected pvd_sel}
    localparam logic [11:0] SEL_VEC [8] = '{
        {3'd0, 3'd7, 3'd0, 3'd6},
        {3'd1, 3'd6, 3'd1, 3'd6},
        {3'd2, 3'd5, 3'd2, 3'd5},
        {3'd3, 3'd4, 3'd3, 3'd4},
        {3'd4, 3'd3, 3'd4, 3'd3},
        {3'd5, 3'd2, 3'd4, 3'd2},
        {3'd6, 3'd1, 3'd4, 3'd1},
        {3'd7, 3'd0, 3'd4, 3'd0}
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        pwr_rst_n = 1'b0; por_ok = 1'b0; bor_opt = 1'b1; bor_low = 1'b0;
        pvd_sw = 1'b0; pvd_low = 1'b0; pvd_clr = 1'b0; gate_en = 1'b0;
        dsleep = 1'b0; wake = 1'b0; bor_lvl = 3'd0; pvd_lvl = 3'd0; settle = '0;
        step(3);
        chk("R1 reset state rst", int'(rst_n_a), 0);
        chk("R6 reset state irq", int'(irq_a), 0);
        pwr_rst_n = 1'b1;
        step(20);
        chk("R1 supply still low", int'(rst_n_a), 0);
        chk("R1 variant supply still low", int'(rst_n_b), 0);

        // R2 / R10 power-up release counts
        por_ok = 1'b1;
        step(HOLD);
        chk("R2 held at HOLD edges", int'(rst_n_a), 0);
        step(1);
        chk("R2 released at HOLD+1", int'(rst_n_a), 1);
        step(PDLY - HOLD - 1);
        chk("R10 held at POR_DLY edges", int'(rst_n_b), 0);
        step(1);
        chk("R10 released at POR_DLY+1", int'(rst_n_b), 1);

        // R5 / R7 level clamp table
        for (int i = 0; i < 8; i++) begin
            bor_lvl = SEL_VEC[i][11:9];
            pvd_lvl = SEL_VEC[i][8:6];
            #1;
            chk("R5 bor level clamp", int'(bsel_a), int'(SEL_VEC[i][5:3]));
            chk("R7 pvd level clamp", int'(psel_a), int'(SEL_VEC[i][2:0]));
        end

        // R4 option off
        bor_opt = 1'b0;
        #1;
        chk("R4 bor_en off", int'(bor_en_a), 0);
        bor_low = 1'b1;
        step(3);
        chk("R4 trip ignored", int'(rst_n_a), 1);
        bor_low = 1'b0;
        bor_opt = 1'b1;
        step(1);

        // R3 immediate assert, timed release; R10 variant ignores
        chk("R3 bor_en on", int'(bor_en_a), 1);
        chk("R10 variant bor_en", int'(bor_en_b), 0);
        bor_low = 1'b1;
        #1;
        chk("R3 same-cycle assert", int'(rst_n_a), 0);
        chk("R10 variant ignores trip", int'(rst_n_b), 1);
        step(3);
        bor_low = 1'b0;
        step(HOLD);
        chk("R3 held after trip", int'(rst_n_a), 0);
        step(1);
        chk("R3 released after trip", int'(rst_n_a), 1);

        // R6 early-warning flag
        pvd_sw = 1'b1;
        #1;
        chk("R6 pvd_en", int'(pvd_en_a), 1);
        pvd_low = 1'b1;
        step(1);
        chk("R6 flag set", int'(irq_a), 1);
        pvd_low = 1'b0;
        step(3);
        chk("R6 flag sticky", int'(irq_a), 1);
        pvd_clr = 1'b1;
        step(1);
        pvd_clr = 1'b0;
        chk("R6 flag cleared", int'(irq_a), 0);
        pvd_low = 1'b1; pvd_clr = 1'b1;
        step(1);
        chk("R6 set wins over clear", int'(irq_a), 1);
        pvd_low = 1'b0;
        step(1);
        pvd_clr = 1'b0;
        chk("R6 clear after collision", int'(irq_a), 0);

        // R8 deep-sleep gating
        dsleep = 1'b1; gate_en = 1'b0;
        step(2);
        chk("R8 no gating when disabled bor", int'(bor_en_a), 1);
        chk("R8 no gating when disabled pvd", int'(pvd_en_a), 1);
        gate_en = 1'b1;
        step(1);
        chk("R8 gated bor_en", int'(bor_en_a), 0);
        chk("R8 gated pvd_en", int'(pvd_en_a), 0);
        dsleep = 1'b0;
        bor_low = 1'b1; pvd_low = 1'b1;
        step(3);
        chk("R8 gated stays off", int'(bor_en_a), 0);
        chk("R8 gated trip ignored", int'(rst_n_a), 1);
        chk("R8 gated flag ignored", int'(irq_a), 0);
        bor_low = 1'b0; pvd_low = 1'b0;
        settle = SW'(4); wake = 1'b1;
        step(1);
        wake = 1'b0;
        chk("R8 wake re-enables bor", int'(bor_en_a), 1);
        chk("R8 wake re-enables pvd", int'(pvd_en_a), 1);

        // R9 settle window: 4 edges after wake
        bor_low = 1'b1; pvd_low = 1'b1;
        #1;
        chk("R9 settle ignores trip", int'(rst_n_a), 1);
        step(3);
        chk("R9 settle ignores trip late", int'(rst_n_a), 1);
        chk("R9 settle ignores flag", int'(irq_a), 0);
        step(1);
        chk("R9 armed after settle", int'(rst_n_a), 0);
        step(1);
        chk("R9 flag after settle", int'(irq_a), 1);
        bor_low = 1'b0; pvd_low = 1'b0;
        step(HOLD + 1);
        chk("R3 recovery after settle", int'(rst_n_a), 1);

        // R1 supply drop mid-run
        por_ok = 1'b0;
        #1;
        chk("R1 supply drop", int'(rst_n_a), 0);
        chk("R1 variant supply drop", int'(rst_n_b), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule